// File: doc/BRIEF.md
# Memory Ordering Violation Detector

This block is a small circular queue that records every memory operation in program order. It holds plain loads and stores, and also the memory micro-ops that a custom instruction launches. The in-order dispatch stage allocates an entry for each operation and gives it a sequence tag and the tag of its parent. Addresses arrive later, in any order, and name the entry by its slot number. A load counts as executed once its address is resolved.

When a store's address resolves, the queue looks for younger loads that have already executed on the same 32-bit word. If it finds any, it picks the oldest one and reports a squash. A load that belongs to a custom instruction is never squashed on its own: the report names the parent, and the whole instruction is replayed. After the report the queue drops every entry that is not older than the squash point, and then it resumes. An operation whose address is marked as a dummy is a no-op and never takes part in a conflict.

The control is a three-state machine. TRACK is the normal state, in which allocation, resolution and retirement are accepted. TRACK goes to SQUASH when a conflict is found. SQUASH lasts one cycle and raises the report. It always goes to FLUSH, which removes the younger entries in one cycle and always returns to TRACK.

Top module: `lsq_order_chk`

## Requirements
- R1: After reset the queue is empty: q_count is 0, alloc_ok is 1, alloc_slot is 0 and squash_valid is 0.
- R2: In TRACK, an allocation is taken when alloc_ok is high. The new entry goes to slot alloc_slot, the slot after the previous one modulo DEPTH, and q_count rises by one. When q_count equals DEPTH, alloc_ok is 0 and an allocation request has no effect.
- R3: A retire request in TRACK frees the oldest entry and lowers q_count by one. A retire request on an empty queue has no effect.
- R4: A resolve of a valid store entry without the dummy flag is checked against every valid, already-resolved, non-dummy load that is younger than the store. If any of these loads has the same address bits [ADDR_W-1:2], squash_valid is high for exactly the one cycle after the resolve edge.
- R5: A load that is older than the store, that is not yet resolved, or that sits on a different word causes no squash.
- R6: A dummy-flagged load never conflicts, and a dummy-flagged store resolve triggers no check.
- R7: When several loads conflict with one store, squash_sid names the oldest of them.
- R8: If the conflicting load is a custom-instruction micro-op (alloc_ci=1), squash_sid is its parent tag and squash_ci is 1; otherwise squash_sid is the load's own tag and squash_ci is 0. The parent tag is the tag of the custom instruction's first micro-op. A custom-instruction store never checks loads that have the same parent.
- R9: The cycle after squash_valid is the flush cycle. At the end of that cycle every entry whose tag is not older than squash_sid is removed, and q_count becomes the number of entries left. During the squash and flush cycles alloc_ok is 0, and allocate, resolve and retire requests have no effect.
- R10: Tags are SEQ_W+1 bits wide, and the top bit is a wrap bit. Tag a is younger than tag b in two cases: the top bits are equal and the low SEQ_W bits of a are greater, or the top bits differ and the low bits of a are smaller. So with SEQ_W=5, tag 0 is younger than tag 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_sid | input | SEQ_W+1 | Sequence tag of the new operation |
| alloc_store | input | 1 | 1 = store, 0 = load |
| alloc_ci | input | 1 | Operation is a custom-instruction micro-op |
| alloc_parent | input | SEQ_W+1 | Parent tag (first micro-op of the custom instruction) |
| alloc_ok | output | 1 | Allocation is accepted this cycle |
| alloc_slot | output | log2(DEPTH) | Slot the next allocation takes |
| res_valid | input | 1 | Address resolution |
| res_slot | input | log2(DEPTH) | Slot being resolved |
| res_addr | input | ADDR_W | Byte address |
| res_dummy | input | 1 | Address is a dummy (no-op) |
| retire_valid | input | 1 | Free the oldest entry |
| q_count | output | log2(DEPTH+1) | Occupied entries |
| squash_valid | output | 1 | Squash report |
| squash_sid | output | SEQ_W+1 | Tag to replay from |
| squash_ci | output | 1 | Squash target is a whole custom instruction |

## Verification
Reaching a conflict from the ports takes a fixed order of events. The younger load must be allocated and resolved first, and only then may the older store resolve. The hardest cases layer more conditions on top of that order. One needs several conflicting loads together with an older load on the same word. Another needs custom-instruction micro-ops that share a parent, with tags that cross the wrap point. A table of short store/load pairs covers the word match, the dummy case and the wrap. Directed sequences then build queues of four or five entries to test oldest-target selection, squashing of a whole custom instruction, and an allocation placed inside the squash cycle that must be ignored.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
    typedef enum logic [1:0] {
        ST_TRACK  = 2'd0,
        ST_SQUASH = 2'd1,
        ST_FLUSH  = 2'd2
    } lsq_state_e;
endpackage

// File: rtl/lsq_age_cmp.sv
module lsq_age_cmp #(
    parameter int SEQ_W = 5
) (
    input  logic [SEQ_W:0] a_sid,
    input  logic [SEQ_W:0] b_sid,
    output logic           a_younger
);
    logic same_lap;

    always_comb begin
        same_lap = (a_sid[SEQ_W] == b_sid[SEQ_W]);
        if (same_lap)
            a_younger = (a_sid[SEQ_W-1:0] > b_sid[SEQ_W-1:0]);
        else
            a_younger = (a_sid[SEQ_W-1:0] < b_sid[SEQ_W-1:0]);
    end
endmodule

// File: rtl/lsq_conflict_scan.sv
module lsq_conflict_scan #(
    parameter int DEPTH   = 16,
    parameter int SEQ_W   = 5,
    parameter int WADDR_W = 30
) (
    input  logic [DEPTH-1:0]   ent_valid,
    input  logic [DEPTH-1:0]   ent_store,
    input  logic [DEPTH-1:0]   ent_ci,
    input  logic [DEPTH-1:0]   ent_done,
    input  logic [DEPTH-1:0]   ent_dummy,
    input  logic [SEQ_W:0]     ent_sid    [DEPTH],
    input  logic [SEQ_W:0]     ent_parent [DEPTH],
    input  logic [WADDR_W-1:0] ent_waddr  [DEPTH],
    input  logic               probe_valid,
    input  logic [SEQ_W:0]     probe_sid,
    input  logic               probe_ci,
    input  logic [SEQ_W:0]     probe_parent,
    input  logic [WADDR_W-1:0] probe_waddr,
    output logic [DEPTH-1:0]   hits
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic is_younger;
        logic same_group;
        logic eligible;

        lsq_age_cmp #(.SEQ_W(SEQ_W)) u_age (
            .a_sid     (ent_sid[i]),
            .b_sid     (probe_sid),
            .a_younger (is_younger)
        );

        assign same_group = probe_ci && ent_ci[i] && (ent_parent[i] == probe_parent);
        assign eligible   = ent_valid[i] && !ent_store[i] && ent_done[i] && !ent_dummy[i];
        assign hits[i]    = probe_valid && eligible && is_younger && !same_group &&
                            (ent_waddr[i] == probe_waddr);
    end
endmodule

// File: rtl/lsq_oldest_pick.sv
module lsq_oldest_pick #(
    parameter int DEPTH = 16
) (
    input  logic [DEPTH-1:0]         hits,
    input  logic [$clog2(DEPTH)-1:0] head,
    output logic                     found,
    output logic [$clog2(DEPTH)-1:0] slot
);
    localparam int IDX_W = $clog2(DEPTH);

    always_comb begin
        logic [IDX_W-1:0] idx;
        found = 1'b0;
        slot  = head;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            idx = head + IDX_W'(k);
            if (hits[idx]) begin
                found = 1'b1;
                slot  = idx;
            end
        end
    end
endmodule

// File: rtl/lsq_squash_fsm.sv
module lsq_squash_fsm
    import lsq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic conflict,
    output logic tracking,
    output logic squash_on,
    output logic flush_on
);
    lsq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_TRACK;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TRACK:  if (conflict) state_d = ST_SQUASH;
            ST_SQUASH: state_d = ST_FLUSH;
            ST_FLUSH:  state_d = ST_TRACK;
            default:   state_d = ST_TRACK;
        endcase
    end

    always_comb begin
        tracking  = 1'b0;
        squash_on = 1'b0;
        flush_on  = 1'b0;
        unique case (state_q)
            ST_TRACK:  tracking  = 1'b1;
            ST_SQUASH: squash_on = 1'b1;
            ST_FLUSH:  flush_on  = 1'b1;
            default:   tracking  = 1'b1;
        endcase
    end
endmodule

// File: rtl/lsq_order_chk.sv
module lsq_order_chk #(
    parameter int DEPTH  = 16,
    parameter int SEQ_W  = 5,
    parameter int ADDR_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       alloc_valid,
    input  logic [SEQ_W:0]             alloc_sid,
    input  logic                       alloc_store,
    input  logic                       alloc_ci,
    input  logic [SEQ_W:0]             alloc_parent,
    output logic                       alloc_ok,
    output logic [$clog2(DEPTH)-1:0]   alloc_slot,
    input  logic                       res_valid,
    input  logic [$clog2(DEPTH)-1:0]   res_slot,
    input  logic [ADDR_W-1:0]          res_addr,
    input  logic                       res_dummy,
    input  logic                       retire_valid,
    output logic [$clog2(DEPTH+1)-1:0] q_count,
    output logic                       squash_valid,
    output logic [SEQ_W:0]             squash_sid,
    output logic                       squash_ci
);
    // DEPTH is a power of two so that slot pointers wrap naturally.
    localparam int IDX_W   = $clog2(DEPTH);
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int WADDR_W = ADDR_W - 2;

    logic [DEPTH-1:0]   v_q, st_q, ci_q, done_q, dum_q;
    logic [SEQ_W:0]     sid_q [DEPTH];
    logic [SEQ_W:0]     par_q [DEPTH];
    logic [WADDR_W-1:0] wa_q  [DEPTH];
    logic [IDX_W-1:0]   head_q, tail_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [SEQ_W:0]     tgt_sid_q;
    logic               tgt_ci_q;

    logic tracking, squash_on, flush_on;
    logic do_alloc, do_retire, res_ok, probe_valid;
    logic [DEPTH-1:0] hits, keep_v;
    logic pick_found;
    logic [IDX_W-1:0] pick_slot;
    logic [CNT_W-1:0] survivors;

    assign alloc_ok   = tracking && (cnt_q != CNT_W'(DEPTH));
    assign do_alloc   = alloc_valid && alloc_ok;
    assign do_retire  = retire_valid && tracking && (cnt_q != '0);
    assign res_ok     = res_valid && tracking && v_q[res_slot];
    assign probe_valid = res_ok && st_q[res_slot] && !res_dummy;

    lsq_conflict_scan #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .WADDR_W(WADDR_W)) u_scan (
        .ent_valid    (v_q),
        .ent_store    (st_q),
        .ent_ci       (ci_q),
        .ent_done     (done_q),
        .ent_dummy    (dum_q),
        .ent_sid      (sid_q),
        .ent_parent   (par_q),
        .ent_waddr    (wa_q),
        .probe_valid  (probe_valid),
        .probe_sid    (sid_q[res_slot]),
        .probe_ci     (ci_q[res_slot]),
        .probe_parent (par_q[res_slot]),
        .probe_waddr  (res_addr[ADDR_W-1:2]),
        .hits         (hits)
    );

    lsq_oldest_pick #(.DEPTH(DEPTH)) u_pick (
        .hits  (hits),
        .head  (head_q),
        .found (pick_found),
        .slot  (pick_slot)
    );

    lsq_squash_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .conflict  (pick_found),
        .tracking  (tracking),
        .squash_on (squash_on),
        .flush_on  (flush_on)
    );

    // An entry survives a flush only if it is strictly older than the target.
    for (genvar i = 0; i < DEPTH; i++) begin : g_keep
        logic ent_older;
        lsq_age_cmp #(.SEQ_W(SEQ_W)) u_age (
            .a_sid     (tgt_sid_q),
            .b_sid     (sid_q[i]),
            .a_younger (ent_older)
        );
        assign keep_v[i] = v_q[i] && ent_older;
    end

    always_comb begin
        survivors = '0;
        for (int i = 0; i < DEPTH; i++)
            survivors = survivors + CNT_W'(keep_v[i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q       <= '0;
            st_q      <= '0;
            ci_q      <= '0;
            done_q    <= '0;
            dum_q     <= '0;
            head_q    <= '0;
            tail_q    <= '0;
            cnt_q     <= '0;
            tgt_sid_q <= '0;
            tgt_ci_q  <= 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                sid_q[i] <= '0;
                par_q[i] <= '0;
                wa_q[i]  <= '0;
            end
        end else if (tracking) begin
            if (do_retire) begin
                v_q[head_q] <= 1'b0;
                head_q      <= head_q + 1'b1;
            end
            if (do_alloc) begin
                v_q[tail_q]    <= 1'b1;
                st_q[tail_q]   <= alloc_store;
                ci_q[tail_q]   <= alloc_ci;
                done_q[tail_q] <= 1'b0;
                dum_q[tail_q]  <= 1'b0;
                sid_q[tail_q]  <= alloc_sid;
                par_q[tail_q]  <= alloc_parent;
                tail_q         <= tail_q + 1'b1;
            end
            if (res_ok) begin
                wa_q[res_slot]   <= res_addr[ADDR_W-1:2];
                dum_q[res_slot]  <= res_dummy;
                done_q[res_slot] <= 1'b1;
            end
            cnt_q <= cnt_q + CNT_W'(do_alloc) - CNT_W'(do_retire);
            if (pick_found) begin
                tgt_sid_q <= ci_q[pick_slot] ? par_q[pick_slot] : sid_q[pick_slot];
                tgt_ci_q  <= ci_q[pick_slot];
            end
        end else if (flush_on) begin
            v_q    <= keep_v;
            cnt_q  <= survivors;
            tail_q <= head_q + survivors[IDX_W-1:0];
        end
    end

    assign alloc_slot   = tail_q;
    assign q_count      = cnt_q;
    assign squash_valid = squash_on;
    assign squash_sid   = tgt_sid_q;
    assign squash_ci    = tgt_ci_q;
endmodule

// File: rtl/lsq_order_chk_sva.sv
module lsq_order_chk_sva #(
    parameter int DEPTH  = 16,
    parameter int SEQ_W  = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       alloc_valid,
    input logic                       alloc_ok,
    input logic                       res_valid,
    input logic                       retire_valid,
    input logic [$clog2(DEPTH+1)-1:0] q_count,
    input logic                       squash_valid,
    input logic [SEQ_W:0]             squash_sid
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |=> !squash_valid);

    a_r9_no_alloc_squash: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> !alloc_ok);

    a_r9_no_alloc_flush: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |=> !alloc_ok);

    a_r4_follows_resolve: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(squash_valid) |-> $past(res_valid));

    a_r9_target_held: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |=> $stable(squash_sid));

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(DEPTH));

    a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == CNT_W'(DEPTH)) |-> !alloc_ok);

    a_r3_retire_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_ok && retire_valid && !alloc_valid && q_count != '0)
        |=> (q_count == $past(q_count) - CNT_W'(1)));
endmodule

bind lsq_order_chk lsq_order_chk_sva #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .alloc_ok     (alloc_ok),
    .res_valid    (res_valid),
    .retire_valid (retire_valid),
    .q_count      (q_count),
    .squash_valid (squash_valid),
    .squash_sid   (squash_sid)
);

// File: tb/lsq_order_chk_test.sv
`timescale 1ns/1ps
module lsq_order_chk_test;
    localparam int DEPTH = 16;
    localparam int SEQ_W = 5;
    localparam int ADDR_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 1'b0;
    logic [SEQ_W:0] alloc_sid = '0;
    logic alloc_store = 1'b0;
    logic alloc_ci = 1'b0;
    logic [SEQ_W:0] alloc_parent = '0;
    logic alloc_ok;
    logic [3:0] alloc_slot;
    logic res_valid = 1'b0;
    logic [3:0] res_slot = '0;
    logic [ADDR_W-1:0] res_addr = '0;
    logic res_dummy = 1'b0;
    logic retire_valid = 1'b0;
    logic [4:0] q_count;
    logic squash_valid;
    logic [SEQ_W:0] squash_sid;
    logic squash_ci;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lsq_order_chk #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W)) uut (.*);

    // Table: store tag, store address, load address, load is CI, load dummy, expect squash
    localparam int NV = 6;
    localparam logic [5:0]  V_SID [NV] = '{6'd0, 6'd0, 6'd0, 6'd10, 6'd20, 6'd63};
    localparam logic [31:0] V_ST  [NV] = '{32'h100, 32'h100, 32'h100, 32'h200, 32'h300, 32'h40};
    localparam logic [31:0] V_LD  [NV] = '{32'h100, 32'h103, 32'h104, 32'h200, 32'h300, 32'h40};
    localparam bit          V_CI  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam bit          V_DUM [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam bit          V_HIT [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic alloc_op(input logic [5:0] sid, input bit st, input bit ci,
                            input logic [5:0] par, output logic [3:0] slot);
        slot = alloc_slot;
        alloc_valid = 1'b1; alloc_sid = sid; alloc_store = st;
        alloc_ci = ci; alloc_parent = par;
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    task automatic resolve(input logic [3:0] slot, input logic [31:0] addr, input bit dum);
        res_valid = 1'b1; res_slot = slot; res_addr = addr; res_dummy = dum;
        @(negedge clk);
        res_valid = 1'b0; res_dummy = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [3:0] s0, s1, s2, s3, s4;
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 count", 32'(q_count), 0);
        chk("R1 alloc_ok", 32'(alloc_ok), 1);
        chk("R1 slot", 32'(alloc_slot), 0);
        chk("R1 squash", 32'(squash_valid), 0);

        // Table walk: R4 R5 R6 R8 R9 R10
        for (int r = 0; r < NV; r++) begin
            logic [5:0] lsid;
            do_reset();
            lsid = V_SID[r] + 6'd1;
            alloc_op(V_SID[r], 1'b1, 1'b0, V_SID[r], s0);
            alloc_op(lsid, 1'b0, V_CI[r], lsid, s1);
            resolve(s1, V_LD[r], V_DUM[r]);
            resolve(s0, V_ST[r], 1'b0);
            chk("R4/R5/R6 squash", 32'(squash_valid), 32'(V_HIT[r]));
            if (V_HIT[r]) begin
                chk("R8/R10 target", 32'(squash_sid), 32'(lsid));
                chk("R8 ci flag", 32'(squash_ci), 32'(V_CI[r]));
            end
            @(negedge clk);
            chk("R9 alloc blocked in flush", 32'(alloc_ok), 32'(!V_HIT[r]));
            @(negedge clk);
            chk("R9 survivors", 32'(q_count), V_HIT[r] ? 1 : 2);
        end

        // R5: older load and unresolved younger load on the same word
        do_reset();
        alloc_op(6'd4, 1'b0, 1'b0, 6'd4, s0);
        alloc_op(6'd5, 1'b1, 1'b0, 6'd5, s1);
        alloc_op(6'd6, 1'b0, 1'b0, 6'd6, s2);
        resolve(s0, 32'h500, 1'b0);
        resolve(s1, 32'h500, 1'b0);
        chk("R5 older/unresolved", 32'(squash_valid), 0);

        // R7 oldest pick; R9 alloc during squash ignored
        do_reset();
        alloc_op(6'd4, 1'b0, 1'b0, 6'd4, s0);
        alloc_op(6'd5, 1'b1, 1'b0, 6'd5, s1);
        alloc_op(6'd6, 1'b0, 1'b0, 6'd6, s2);
        alloc_op(6'd7, 1'b0, 1'b0, 6'd7, s3);
        resolve(s0, 32'h600, 1'b0);
        resolve(s3, 32'h600, 1'b0);
        resolve(s2, 32'h600, 1'b0);
        resolve(s1, 32'h600, 1'b0);
        chk("R7 squash", 32'(squash_valid), 1);
        chk("R7 oldest", 32'(squash_sid), 6);
        chk("R9 alloc_ok low in squash", 32'(alloc_ok), 0);
        alloc_op(6'd3, 1'b0, 1'b0, 6'd3, s4);
        @(negedge clk);
        chk("R9 alloc ignored, survivors", 32'(q_count), 2);
        chk("R9 tail after flush", 32'(alloc_slot), 2);

        // R8 whole custom instruction; same-parent store does not check
        do_reset();
        alloc_op(6'd9,  1'b1, 1'b0, 6'd9,  s0);
        alloc_op(6'd10, 1'b1, 1'b1, 6'd10, s1);
        alloc_op(6'd11, 1'b0, 1'b1, 6'd10, s2);
        alloc_op(6'd12, 1'b0, 1'b1, 6'd10, s3);
        resolve(s2, 32'h700, 1'b0);
        resolve(s1, 32'h700, 1'b0);
        chk("R8 same parent", 32'(squash_valid), 0);
        resolve(s3, 32'h800, 1'b0);
        resolve(s0, 32'h800, 1'b0);
        chk("R8 squash", 32'(squash_valid), 1);
        chk("R8 parent tag", 32'(squash_sid), 10);
        chk("R8 ci", 32'(squash_ci), 1);
        repeat (2) @(negedge clk);
        chk("R8 whole CI flushed", 32'(q_count), 1);

        // R2 full, R3 retire
        do_reset();
        for (int i = 0; i < DEPTH; i++) alloc_op(6'(i), 1'b0, 1'b0, 6'(i), s0);
        chk("R2 full count", 32'(q_count), 16);
        chk("R2 full alloc_ok", 32'(alloc_ok), 0);
        chk("R2 slot wrap", 32'(alloc_slot), 0);
        alloc_op(6'd20, 1'b0, 1'b0, 6'd20, s0);
        chk("R2 alloc ignored when full", 32'(q_count), 16);
        retire_valid = 1'b1;
        @(negedge clk);
        retire_valid = 1'b0;
        chk("R3 retire", 32'(q_count), 15);
        chk("R3 alloc_ok after retire", 32'(alloc_ok), 1);
        do_reset();
        retire_valid = 1'b1;
        @(negedge clk);
        retire_valid = 1'b0;
        chk("R3 retire on empty", 32'(q_count), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule